// File: doc/BRIEF.md
# Power-Management Event Output Controller

This block turns a wake detection strobe into the signal on a power-management event pin. A wake indication from the network receive logic is latched into a sticky status flag. Software clears the flag by writing one to it. While the flag is set and the pin is enabled, the pin is asserted in one of two ways. In pulse mode it is asserted for a fixed number of clock cycles. In level mode it stays asserted until the flag or the enable is cleared.

Software sets up the pin through a single control/status word on a plain write-strobe / read-data port.

- **Pad type.** The pin can act as a push-pull driver, which honours a polarity bit. It can also act as an open-drain output for wired-OR sharing. In that case it always signals active low by pulling the line low and otherwise releasing it.
- **Drive enable.** A separate drive-enable output lets the pad be modelled outside the block.
- **Ready flag.** A read-only ready flag rises a fixed number of cycles after reset. Writes made before it rises are dropped.

Top module: `pme_out_ctrl`

## Requirements
- R1: Bit 0 of the read word (ready) reads 0 from reset and becomes 1 exactly READY_DLY clock edges after reset is released. A write presented while it reads 0 changes nothing.
- R2: The read word has a fixed layout. Bit 1 is pin enable, bit 2 is active-high select, bit 3 is level mode (1) versus pulse mode (0), and bit 4 is push-pull (1) versus open-drain (0). Bit 5 is the wake status flag. Bits 1 to 4 read back what was written. All other bits read 0, and bits 1 to 5 reset to 0.
- R3: A wake_evt sampled high at a clock edge sets the status flag from that edge on. While wake_evt stays high, the flag cannot be cleared.
- R4: Writing a 1 to bit 5 clears the status flag at that edge, provided wake_evt is low. Writing a 0 to bit 5 leaves the flag unchanged.
- R5: In level mode, the pin is asserted whenever the pin enable and the status flag are both 1.
- R6: In pulse mode, a rising edge of the status flag gives exactly PULSE_CYC asserted cycles, beginning one cycle after the flag rises.
- R7: A wake event that arrives while the flag is already set does not restart or extend a pulse. A new pulse needs the flag to be cleared and set again.
- R8: In push-pull mode, pme_oe is 1. pme_o equals the asserted state when active-high is selected, and its inverse otherwise.
- R9: In open-drain mode, pme_o is always 0 and pme_oe equals the asserted state, whatever the polarity bit holds.
- R10: With the pin enable at 0, or the status flag at 0, the pin sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_evt | input | 1 | Wake detection indication from the receive logic |
| reg_wr_en | input | 1 | Write strobe for the control/status word |
| reg_wr_data | input | REG_W | Write data |
| reg_rd_data | output | REG_W | Current control/status word |
| pme_o | output | 1 | Event pin data |
| pme_oe | output | 1 | Event pin drive enable |

## Verification
The hardest case to reach is a second wake indication arriving while a pulse is still running. The bench must show that the pulse length is unchanged and that a fresh pulse appears only after a clear. To get there, the stimulus raises wake_evt again a few cycles into a pulse. It then counts asserted cycles over a window longer than the pulse. After that it clears the flag and re-arms. The bench also presents a clear in the same cycle as a held wake_evt. It also issues writes in the cycles before ready rises, including the edge at which ready goes high.

// File: rtl/pme_pkg.sv
package pme_pkg;
    localparam int BIT_READY = 0;
    localparam int BIT_EN    = 1;
    localparam int BIT_HIGH  = 2;
    localparam int BIT_LEVEL = 3;
    localparam int BIT_PP    = 4;
    localparam int BIT_STS   = 5;

    typedef struct packed {
        logic pin_en;
        logic active_high;
        logic level_mode;
        logic push_pull;
    } pme_cfg_t;
endpackage

// File: rtl/pme_ready_timer.sv
module pme_ready_timer #(
    parameter int READY_DLY = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = (READY_DLY < 2) ? 1 : $clog2(READY_DLY);
    localparam logic [CW-1:0] LAST = CW'(READY_DLY - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } rt_state_t;

    rt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.rdy) begin
            if (st_q.cnt == LAST) st_d.rdy = 1'b1;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.rdy;
endmodule

// File: rtl/pme_event_core.sv
module pme_event_core #(
    parameter int PULSE_CYC = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_evt,
    input  logic clr_req,
    input  logic pin_en,
    input  logic level_mode,
    output logic sts,
    output logic assert_o
);
    localparam int TW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
    localparam logic [TW-1:0] LOAD = TW'(PULSE_CYC - 1);

    typedef struct packed {
        logic          sts;
        logic          sts_prev;
        logic          run;
        logic [TW-1:0] left;
    } ev_state_t;

    ev_state_t st_d, st_q;
    logic      rise;

    always_comb begin
        st_d          = st_q;
        rise          = st_q.sts && !st_q.sts_prev;
        st_d.sts      = wake_evt || (st_q.sts && !clr_req);
        st_d.sts_prev = st_q.sts;
        if (!st_q.sts) begin
            st_d.run  = 1'b0;
            st_d.left = '0;
        end else if (rise && !st_q.run) begin
            st_d.run  = 1'b1;
            st_d.left = LOAD;
        end else if (st_q.run) begin
            if (st_q.left == '0) st_d.run  = 1'b0;
            else                 st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts      = st_q.sts;
    assign assert_o = pin_en && st_q.sts && (level_mode || st_q.run);
endmodule

// File: rtl/pme_pad_drive.sv
module pme_pad_drive (
    input  logic assert_i,
    input  logic push_pull,
    input  logic active_high,
    output logic pad_o,
    output logic pad_oe
);
    always_comb begin
        if (push_pull) begin
            pad_oe = 1'b1;
            pad_o  = active_high ? assert_i : !assert_i;
        end else begin
            pad_oe = assert_i;
            pad_o  = 1'b0;
        end
    end
endmodule

// File: rtl/pme_out_ctrl.sv
module pme_out_ctrl
    import pme_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int READY_DLY = 64,
    parameter int PULSE_CYC = 2500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_evt,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             pme_o,
    output logic             pme_oe
);
    pme_cfg_t cfg_d, cfg_q;
    logic     ready, wr_ok, clr_req, sts, active;
    logic     unused_wdata;

    assign unused_wdata = ^{reg_wr_data[REG_W-1:BIT_STS+1], reg_wr_data[BIT_READY]};

    pme_ready_timer #(.READY_DLY(READY_DLY)) u_ready (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    always_comb begin
        wr_ok   = reg_wr_en && ready;
        clr_req = wr_ok && reg_wr_data[BIT_STS];
        cfg_d   = cfg_q;
        if (wr_ok) begin
            cfg_d.pin_en      = reg_wr_data[BIT_EN];
            cfg_d.active_high = reg_wr_data[BIT_HIGH];
            cfg_d.level_mode  = reg_wr_data[BIT_LEVEL];
            cfg_d.push_pull   = reg_wr_data[BIT_PP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    pme_event_core #(.PULSE_CYC(PULSE_CYC)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_evt   (wake_evt),
        .clr_req    (clr_req),
        .pin_en     (cfg_q.pin_en),
        .level_mode (cfg_q.level_mode),
        .sts        (sts),
        .assert_o   (active)
    );

    pme_pad_drive u_pad (
        .assert_i    (active),
        .push_pull   (cfg_q.push_pull),
        .active_high (cfg_q.active_high),
        .pad_o       (pme_o),
        .pad_oe      (pme_oe)
    );

    always_comb begin
        reg_rd_data            = '0;
        reg_rd_data[BIT_READY] = ready;
        reg_rd_data[BIT_EN]    = cfg_q.pin_en;
        reg_rd_data[BIT_HIGH]  = cfg_q.active_high;
        reg_rd_data[BIT_LEVEL] = cfg_q.level_mode;
        reg_rd_data[BIT_PP]    = cfg_q.push_pull;
        reg_rd_data[BIT_STS]   = sts;
    end
endmodule

// File: rtl/pme_out_ctrl_chk.sv
module pme_out_ctrl_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wake_evt,
    input logic             reg_wr_en,
    input logic [REG_W-1:0] reg_rd_data,
    input logic             pme_o,
    input logic             pme_oe
);
    logic idle_level_ok;
    assign idle_level_ok = reg_rd_data[4] ? (pme_oe && (pme_o == !reg_rd_data[2])) : !pme_oe;

    p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[0] |=> reg_rd_data[0]);

    p_wr_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd_data[0] && reg_wr_en) |=> (reg_rd_data[4:1] == $past(reg_rd_data[4:1])));

    p_sts_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> reg_rd_data[5]);

    p_pp_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[4] |-> pme_oe);

    p_od_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_data[4] |-> !pme_o);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd_data[1] || !reg_rd_data[5]) |-> idle_level_ok);
endmodule

bind pme_out_ctrl pme_out_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_evt    (wake_evt),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data),
    .pme_o       (pme_o),
    .pme_oe      (pme_oe)
);

// File: tb/pme_out_ctrl_test.sv
`timescale 1ns/1ps
module pme_out_ctrl_test;
    localparam int RDY = 8;
    localparam int PUL = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wake_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pme_o, pme_oe;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pme_out_ctrl #(.REG_W(32), .READY_DLY(RDY), .PULSE_CYC(PUL)) uut (
        .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .reg_wr_en(wr_en),
        .reg_wr_data(wr_data), .reg_rd_data(rd_data), .pme_o(pme_o), .pme_oe(pme_oe)
    );

    // behavioural reference
    int m_edges, m_rem;
    bit m_rdy, m_en, m_hi, m_lvl, m_pp, m_sts, m_prev;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit ok, rise, asr;
        logic [31:0] erd;
        if (!rst_n) begin
            m_edges = 0; m_rem = 0; m_rdy = 0; m_en = 0; m_hi = 0;
            m_lvl = 0; m_pp = 0; m_sts = 0; m_prev = 0;
        end else begin
            ok   = wr_en && m_rdy;
            rise = m_sts && !m_prev;
            if (!m_sts) m_rem = 0;
            else if (rise && m_rem == 0) m_rem = PUL;
            else if (m_rem > 0) m_rem--;
            m_prev = m_sts;
            m_sts  = wake_evt || (m_sts && !(ok && wr_data[5]));
            if (ok) begin
                m_en = wr_data[1]; m_hi = wr_data[2]; m_lvl = wr_data[3]; m_pp = wr_data[4];
            end
            m_edges++;
            if (m_edges >= RDY) m_rdy = 1;
        end
        #1;
        erd = {26'd0, m_sts, m_pp, m_lvl, m_hi, m_en, m_rdy};
        asr = m_en && m_sts && (m_lvl || m_rem > 0);
        check("R2 read word", rd_data, erd);
        if (m_pp) check("R8 pad {oe,o}", {30'd0, pme_oe, pme_o}, {30'd0, 1'b1, m_hi ? asr : !asr});
        else      check("R9 pad {oe,o}", {30'd0, pme_oe, pme_o}, {30'd0, asr, 1'b0});
    end

    task automatic wr(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic evt_pulse();
        @(negedge clk); wake_evt = 1'b1;
        @(negedge clk); wake_evt = 1'b0;
    endtask

    task automatic count_active(input bit level_hi, input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(posedge clk); #1;
            if (pme_o == level_hi) n++;
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R2 reset word", rd_data, 32'h0);
        check("R9 reset pad", {30'd0, pme_oe, pme_o}, 32'h0);
        rst_n = 1'b1;
        // R1: writes before ready are dropped
        wr(32'h0000_001E);
        wr(32'h0000_001E);
        check("R1 early write ignored", {27'd0, rd_data[4:1]}, 32'h0);
        repeat (RDY) @(negedge clk);
        check("R1 ready set", {31'd0, rd_data[0]}, 32'h1);

        // R5 level mode, push-pull, active high
        wr(32'h0000_001E);
        evt_pulse();
        @(negedge clk);
        check("R3 status latched", {31'd0, rd_data[5]}, 32'h1);
        check("R5 level asserted", {31'd0, pme_o}, 32'h1);
        // R3 clear while event held is refused
        @(negedge clk); wake_evt = 1'b1;
        wr(32'h0000_003E);
        check("R3 clear refused", {31'd0, rd_data[5]}, 32'h1);
        @(negedge clk); wake_evt = 1'b0;
        wr(32'h0000_001E);
        check("R4 zero write keeps", {31'd0, rd_data[5]}, 32'h1);
        wr(32'h0000_003E);
        check("R4 cleared", {31'd0, rd_data[5]}, 32'h0);
        check("R10 idle after clear", {31'd0, pme_o}, 32'h0);

        // R6 pulse mode
        wr(32'h0000_0016);
        evt_pulse();
        count_active(1'b1, 3 * PUL, n);
        check("R6 pulse length", n, PUL);
        wr(32'h0000_0036);

        // R7 second event mid-pulse
        evt_pulse();
        repeat (5) @(negedge clk);
        wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
        count_active(1'b1, 3 * PUL, n);
        check("R7 no restart total", n, PUL - 6);
        evt_pulse();
        count_active(1'b1, 2 * PUL, n);
        check("R7 no pulse while set", n, 0);
        wr(32'h0000_0036);
        evt_pulse();
        count_active(1'b1, 3 * PUL, n);
        check("R7 fresh pulse", n, PUL);
        wr(32'h0000_0036);

        // R8 push-pull active low, level
        wr(32'h0000_001A);
        check("R8 idle high", {30'd0, pme_oe, pme_o}, 32'h3);
        evt_pulse();
        @(negedge clk);
        check("R8 asserted low", {30'd0, pme_oe, pme_o}, 32'h2);
        wr(32'h0000_003A);

        // R9 open drain ignores polarity
        wr(32'h0000_000E);
        check("R9 released", {30'd0, pme_oe, pme_o}, 32'h0);
        evt_pulse();
        @(negedge clk);
        check("R9 pulled low", {30'd0, pme_oe, pme_o}, 32'h2);

        // R10 enable off holds inactive with status set
        wr(32'h0000_001C);
        check("R10 status still set", {31'd0, rd_data[5]}, 32'h1);
        check("R10 disabled idle", {30'd0, pme_oe, pme_o}, 32'h2);
        wr(32'h0000_003C);

        // R2 reserved bits
        wr(32'hFFFF_FFC0);
        check("R2 reserved zero", rd_data, 32'h1);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule